// File: doc/BRIEF.md
# Passive Optical Network Receive Link-ID Filter

This block sits on the receive side of a passive optical network reconciliation layer. It takes a 32-bit, four-lane column stream with one control flag per lane, in which lane 0 occupies bits 7:0 and is first in time. A frame opens with a start character in lane 0 of a column. The block checks for a start-of-link-ID delimiter in lane 2 of that same column. It reads a mode bit and a 15-bit link identifier from the next column, and decides whether the frame belongs to this end of the link. A frame that belongs is forwarded with the delimiter and identifier octets rewritten as ordinary preamble octets. Any other frame is replaced by idle columns.

A static input selects between head-end (OLT) rules and subscriber-end (ONU) rules. In head-end mode, up to four configured entries are compared, and the one that matches is reported by index. In subscriber-end mode, entry 0 holds the local identifier, and two multicast identifier registers widen the accepted set. The decision waits for the identifier column, so every column leaves the block two columns after it entered.

Top module: `pon_rx_link_filter`

## Requirements
- R1: Each output column is the input column from two clock cycles earlier. Columns outside a frame, including data not preceded by a start, pass unchanged.
- R2: A frame start is recognised only as control lane 0 carrying 0xFB. A frame is forwarded only if lane 2 of that start column is data 0xD5. A 0xFB in any other lane is not a start.
- R3: In the start column of a forwarded frame, lane 2 leaves as 0x55, and lanes 0, 1 and 3 leave unchanged.
- R4: The identifier column is the column right after the start column. Bit 15 is the mode bit, bits 14:8 are identifier bits 14:8, and bits 23:16 are identifier bits 7:0. In a forwarded frame, lanes 1 and 2 of this column leave as 0x55, lanes 0 and 3 leave unchanged, and all later columns leave unchanged.
- R5: In head-end mode the mode bit is ignored. An identifier of 0x7FFF, 0x7FFE or 0x7FFD matches an enabled entry holding that value, whatever the entry's mode.
- R6: In head-end mode, any other identifier matches only an enabled entry whose mode is 0 and whose identifier is equal to it. Disabled entries never match.
- R7: In subscriber-end mode the frame matches in either of two cases: the mode bit is 0 and the identifier equals entry 0's identifier, or the mode bit is 1 and the identifier differs from it.
- R8: In subscriber-end mode, an identifier of 0x7FFD always matches. An identifier equal to an enabled multicast register also matches.
- R9: A frame that does not match is output as idle columns (data 0x07 in every lane, control 4'hF), up to and including the column holding the terminate character 0xFD. Columns after it pass unchanged again.
- R10: out_sof pulses for one cycle with the forwarded start column. out_idx gives the lowest-numbered matching entry in head-end mode and 0 in subscriber-end mode.
- R11: After reset, the outputs are idle columns with out_sof low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Synchronous active-low reset |
| olt_mode | input | 1 | 1 selects head-end rules, 0 selects subscriber-end rules (static) |
| rx_data | input | 32 | Received column, lane 0 in bits 7:0 |
| rx_ctrl | input | 4 | Per-lane control flags of the received column |
| ent_en | input | 4 | Enable bit of each entry |
| ent_mode | input | 4 | Mode bit of each entry |
| ent_id | input | 60 | Entry identifiers, entry i in bits 15i+14:15i |
| mc_en | input | 2 | Enable of each multicast register |
| mc_id | input | 30 | Multicast identifiers, register j in bits 15j+14:15j |
| out_data | output | 32 | Filtered column |
| out_ctrl | output | 4 | Control flags of the filtered column |
| out_sof | output | 1 | Pulse with the start column of a forwarded frame |
| out_idx | output | 2 | Index of the matched entry, valid with out_sof |

## Verification
Every output is due exactly two clock edges after its column is sampled. The bench drives each column on a falling edge. On the same falling edge it reads the output belonging to the column driven two falling edges earlier, so each compare falls in the cycle the result becomes visible. out_sof and out_idx are read in the cycle that shows the start column, and out_sof is read again one cycle later to confirm the pulse lasts one cycle. Dropped frames are checked column by column through the terminate column and the idle column after it.

// File: rtl/pon_rx_pkg.sv
// Package: shared column character codes for the receive link-ID filter.
// Assumes a four-lane column with one control flag per lane.
package pon_rx_pkg;
    localparam int          LANES   = 4;
    localparam int          COL_W   = LANES * 8;
    localparam logic [7:0]  CH_START = 8'hFB;
    localparam logic [7:0]  CH_TERM  = 8'hFD;
    localparam logic [7:0]  CH_IDLE  = 8'h07;
    localparam logic [7:0]  CH_PRE   = 8'h55;
    localparam logic [7:0]  CH_SLD   = 8'hD5;
endpackage

// File: rtl/pon_col_scan.sv
// Module: classifies one column. It reports whether the column opens a
// frame (control start character in lane 0 only) and whether any lane
// carries a control terminate character. Purely combinational.
module pon_col_scan
    import pon_rx_pkg::*;
(
    input  logic [COL_W-1:0] col_data,
    input  logic [LANES-1:0] col_ctrl,
    output logic             is_start,
    output logic             has_term
);
    logic [LANES-1:0] lane_term;

    // per-lane terminate detection
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_term[l] = col_ctrl[l] && (col_data[8*l +: 8] == CH_TERM);
    end

    // start is valid only in lane 0
    assign is_start = col_ctrl[0] && (col_data[7:0] == CH_START);
    assign has_term = |lane_term;
endmodule

// File: rtl/pon_link_match.sv
// Module: applies head-end or subscriber-end matching to a received mode
// bit and link identifier. In head-end mode it returns the lowest matching
// entry index. In subscriber-end mode entry 0 holds the local identifier.
// Assumes ID_W >= 2 so the three reserved values are distinct.
module pon_link_match #(
    parameter int N_ENTRY = 4,
    parameter int N_MCAST = 2,
    parameter int ID_W    = 15,
    parameter int IDX_W   = 2
) (
    input  logic                    olt_mode,
    input  logic                    rx_mode,
    input  logic [ID_W-1:0]         rx_id,
    input  logic [N_ENTRY-1:0]      ent_en,
    input  logic [N_ENTRY-1:0]      ent_mode,
    input  logic [N_ENTRY*ID_W-1:0] ent_id,
    input  logic [N_MCAST-1:0]      mc_en,
    input  logic [N_MCAST*ID_W-1:0] mc_id,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);
    localparam logic [ID_W-1:0] RES_HI  = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] RES_MID = RES_HI - ID_W'(1);
    localparam logic [ID_W-1:0] RES_LO  = RES_HI - ID_W'(2);

    logic             reserved;
    logic [N_ENTRY-1:0] ent_hit;
    logic [N_MCAST-1:0] mc_hit;
    logic             onu_hit;
    logic [ID_W-1:0]  local_id;

    assign reserved = (rx_id == RES_HI) || (rx_id == RES_MID) || (rx_id == RES_LO);
    assign local_id = ent_id[ID_W-1:0];

    // head-end comparison per entry
    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
        assign ent_hit[i] = ent_en[i] && (ent_id[i*ID_W +: ID_W] == rx_id)
                            && (reserved || !ent_mode[i]);
    end

    // multicast comparison per register
    for (genvar j = 0; j < N_MCAST; j++) begin : g_mc
        assign mc_hit[j] = mc_en[j] && (mc_id[j*ID_W +: ID_W] == rx_id);
    end

    // subscriber-end rule set
    assign onu_hit = (!rx_mode && (rx_id == local_id))
                  || (rx_mode && (rx_id != local_id))
                  || (rx_id == RES_LO)
                  || (|mc_hit);

    // lowest-index priority select and mode choice
    always_comb begin
        hit_idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (ent_hit[i]) hit_idx = IDX_W'(i);
        end
        if (!olt_mode) hit_idx = '0;
        hit = olt_mode ? (|ent_hit) : onu_hit;
    end
endmodule

// File: rtl/pon_rx_link_filter.sv
// Module: receive link-ID filter. It holds one column, decides the fate of
// a frame when the identifier column arrives, and registers the result,
// giving a fixed two-column latency. Forwarded frames have the delimiter
// and identifier octets rewritten as preamble. Rejected frames become
// idle columns through the terminate column.
// Assumes olt_mode and all configuration inputs are static during frames.
module pon_rx_link_filter
    import pon_rx_pkg::*;
#(
    parameter int N_ENTRY = 4,
    parameter int N_MCAST = 2,
    parameter int ID_W    = 15,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    olt_mode,
    input  logic [COL_W-1:0]        rx_data,
    input  logic [LANES-1:0]        rx_ctrl,
    input  logic [N_ENTRY-1:0]      ent_en,
    input  logic [N_ENTRY-1:0]      ent_mode,
    input  logic [N_ENTRY*ID_W-1:0] ent_id,
    input  logic [N_MCAST-1:0]      mc_en,
    input  logic [N_MCAST*ID_W-1:0] mc_id,
    output logic [COL_W-1:0]        out_data,
    output logic [LANES-1:0]        out_ctrl,
    output logic                    out_sof,
    output logic [IDX_W-1:0]        out_idx
);
    localparam logic [COL_W-1:0] IDLE_COL = {LANES{CH_IDLE}};

    logic [COL_W-1:0] hold_d;
    logic [LANES-1:0] hold_c;
    logic             hold_start, hold_term;
    logic             fwd_q, drop_q, id_col_q;
    logic             sld_ok, id_ok, hit;
    logic [IDX_W-1:0] hit_idx;
    logic             rx_mode;
    logic [ID_W-1:0]  rx_id;

    pon_col_scan u_scan (
        .col_data (hold_d),
        .col_ctrl (hold_c),
        .is_start (hold_start),
        .has_term (hold_term)
    );

    // identifier fields come from the incoming column
    assign rx_mode = rx_data[15];
    assign rx_id   = ID_W'({rx_data[14:8], rx_data[23:16]});
    assign id_ok   = !rx_ctrl[1] && !rx_ctrl[2];
    assign sld_ok  = !hold_c[2] && (hold_d[23:16] == CH_SLD);

    pon_link_match #(
        .N_ENTRY (N_ENTRY),
        .N_MCAST (N_MCAST),
        .ID_W    (ID_W),
        .IDX_W   (IDX_W)
    ) u_match (
        .olt_mode (olt_mode),
        .rx_mode  (rx_mode),
        .rx_id    (rx_id),
        .ent_en   (ent_en),
        .ent_mode (ent_mode),
        .ent_id   (ent_id),
        .mc_en    (mc_en),
        .mc_id    (mc_id),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    // column pipeline, frame decision and octet rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_d   <= IDLE_COL;
            hold_c   <= '1;
            out_data <= IDLE_COL;
            out_ctrl <= '1;
            out_sof  <= 1'b0;
            out_idx  <= '0;
            fwd_q    <= 1'b0;
            drop_q   <= 1'b0;
            id_col_q <= 1'b0;
        end else begin
            hold_d  <= rx_data;
            hold_c  <= rx_ctrl;
            out_sof <= 1'b0;
            if (hold_start) begin
                if (sld_ok && id_ok && hit) begin
                    out_data <= {hold_d[31:24], CH_PRE, hold_d[15:0]};
                    out_ctrl <= hold_c;
                    out_sof  <= 1'b1;
                    out_idx  <= hit_idx;
                    fwd_q    <= 1'b1;
                    drop_q   <= 1'b0;
                    id_col_q <= 1'b1;
                end else begin
                    out_data <= IDLE_COL;
                    out_ctrl <= '1;
                    fwd_q    <= 1'b0;
                    drop_q   <= 1'b1;
                    id_col_q <= 1'b0;
                end
            end else if (fwd_q) begin
                out_data <= id_col_q ? {hold_d[31:24], CH_PRE, CH_PRE, hold_d[7:0]} : hold_d;
                out_ctrl <= hold_c;
                id_col_q <= 1'b0;
                if (hold_term) fwd_q <= 1'b0;
            end else if (drop_q) begin
                out_data <= IDLE_COL;
                out_ctrl <= '1;
                if (hold_term) drop_q <= 1'b0;
            end else begin
                out_data <= hold_d;
                out_ctrl <= hold_c;
            end
        end
    end

    // a forwarded start column keeps its start character
    assert_sof_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_ctrl[0] && out_data[7:0] == CH_START));

    // the delimiter lane is rewritten as preamble
    assert_sld_rewrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_data[23:16] == CH_PRE && !out_ctrl[2]));

    // rejected frame body leaves as idle
    assert_drop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && !hold_start) |=> (out_ctrl == '1 && out_data == IDLE_COL && !out_sof));

    // forwarding and discarding never overlap
    assert_state_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_q && drop_q));

    // head-end match reports an enabled entry
    assert_idx_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (olt_mode && out_sof && $stable(ent_en)) |-> ent_en[out_idx]);

    // a sof pulse lasts one cycle
    assert_sof_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof);
endmodule

// File: tb/pon_rx_link_filter_bench.sv
module pon_rx_link_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        olt_mode = 1'b1;
    logic [31:0] rx_data = 32'h0707_0707;
    logic [3:0]  rx_ctrl = 4'hF;
    logic [3:0]  ent_en;
    logic [3:0]  ent_mode;
    logic [59:0] ent_id;
    logic [1:0]  mc_en;
    logic [29:0] mc_id;
    logic [31:0] out_data;
    logic [3:0]  out_ctrl;
    logic        out_sof;
    logic [1:0]  out_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] IDLE = 32'h0707_0707;

    always #4 clk = ~clk;

    pon_rx_link_filter u_pon_rx_link_filter (
        .clk (clk), .rst_n (rst_n), .olt_mode (olt_mode),
        .rx_data (rx_data), .rx_ctrl (rx_ctrl),
        .ent_en (ent_en), .ent_mode (ent_mode), .ent_id (ent_id),
        .mc_en (mc_en), .mc_id (mc_id),
        .out_data (out_data), .out_ctrl (out_ctrl),
        .out_sof (out_sof), .out_idx (out_idx)
    );

    // vector: {olt, sld[7:0], mode, id[14:0], pass, idx[1:0]}
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 8'hD5, 1'b0, 15'h0012, 1'b1, 2'd0},   // R6 unicast match
        {1'b1, 8'hD5, 1'b1, 15'h0012, 1'b1, 2'd0},   // R5 mode bit ignored
        {1'b1, 8'hD5, 1'b0, 15'h0034, 1'b0, 2'd0},   // R6 entry mode 1
        {1'b1, 8'hD5, 1'b0, 15'h7FFD, 1'b1, 2'd2},   // R5 reserved, entry mode 1
        {1'b1, 8'hD5, 1'b0, 15'h7FFE, 1'b0, 2'd0},   // R5 reserved, no entry
        {1'b1, 8'hD5, 1'b0, 15'h0056, 1'b0, 2'd0},   // R6 disabled entry
        {1'b1, 8'hA5, 1'b0, 15'h0012, 1'b0, 2'd0},   // R2 bad delimiter
        {1'b0, 8'hD5, 1'b0, 15'h0012, 1'b1, 2'd0},   // R7 local unicast
        {1'b0, 8'hD5, 1'b1, 15'h0012, 1'b0, 2'd0},   // R7 mode 1, same id
        {1'b0, 8'hD5, 1'b1, 15'h0099, 1'b1, 2'd0},   // R7 mode 1, other id
        {1'b0, 8'hD5, 1'b0, 15'h0099, 1'b0, 2'd0},   // R7 mode 0, other id
        {1'b0, 8'hD5, 1'b0, 15'h7FFD, 1'b1, 2'd0},   // R8 broadcast
        {1'b0, 8'hD5, 1'b0, 15'h0100, 1'b1, 2'd0},   // R8 multicast
        {1'b0, 8'hD5, 1'b0, 15'h0200, 1'b0, 2'd0}    // R8 disabled multicast
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // send one frame and compare every output column at its due cycle
    task automatic run_frame(input logic olt, input logic [7:0] sld, input logic m,
                             input logic [14:0] id, input logic pass,
                             input logic [1:0] idx, input string tag);
        logic [31:0] cd [5];
        logic [3:0]  cc [5];
        logic [31:0] ed [5];
        logic [3:0]  ec [5];
        @(negedge clk);
        olt_mode = olt;
        cd[0] = {8'h55, sld, 8'h55, 8'hFB};              cc[0] = 4'b0001;
        cd[1] = {8'hC3, id[7:0], m, id[14:8], 8'h55};    cc[1] = 4'b0000;
        cd[2] = 32'hDEAD_BE00 ^ {16'h0, id[7:0], 8'h0};  cc[2] = 4'b0000;
        cd[3] = 32'h0707_07FD;                           cc[3] = 4'b1111;
        cd[4] = IDLE;                                    cc[4] = 4'b1111;
        for (int k = 0; k < 5; k++) begin
            ed[k] = pass ? cd[k] : IDLE;
            ec[k] = pass ? cc[k] : 4'hF;
        end
        ed[4] = IDLE; ec[4] = 4'hF;
        if (pass) begin
            ed[0] = {8'h55, 8'h55, 8'h55, 8'hFB};
            ed[1] = {8'hC3, 8'h55, 8'h55, 8'h55};
        end
        for (int c = 0; c < 7; c++) begin
            if (c > 0) @(negedge clk);
            if (c >= 2) begin
                check({tag, " R3 R4 R9 data"}, 64'(out_data), 64'(ed[c-2]));
                check({tag, " R1 R9 ctrl"}, 64'(out_ctrl), 64'(ec[c-2]));
                if (c == 2) begin
                    check({tag, " R10 sof"}, 64'(out_sof), 64'(pass));
                    if (pass) check({tag, " R10 idx"}, 64'(out_idx), 64'(idx));
                end
                if (c == 3) check({tag, " R10 pulse"}, 64'(out_sof), 64'(0));
            end
            if (c < 5) begin
                rx_data = cd[c];
                rx_ctrl = cc[c];
            end
        end
    endtask

    // send one column outside a frame and expect it two cycles later
    task automatic pass_col(input logic [31:0] d, input logic [3:0] c, input string tag);
        @(negedge clk);
        rx_data = d; rx_ctrl = c;
        @(negedge clk);
        rx_data = IDLE; rx_ctrl = 4'hF;
        @(negedge clk);
        check({tag, " data"}, 64'(out_data), 64'(d));
        check({tag, " ctrl"}, 64'(out_ctrl), 64'(c));
        check({tag, " sof"}, 64'(out_sof), 64'(0));
    endtask

    initial begin
        ent_en   = 4'b0111;
        ent_mode = 4'b0110;
        ent_id   = {15'h0056, 15'h7FFD, 15'h0034, 15'h0012};
        mc_en    = 2'b01;
        mc_id    = {15'h0200, 15'h0100};
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 reset data", 64'(out_data), 64'(IDLE));
        check("R11 reset ctrl", 64'(out_ctrl), 64'(4'hF));
        check("R11 reset sof", 64'(out_sof), 64'(0));
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            run_frame(VEC[v][27], VEC[v][26:19], VEC[v][18], VEC[v][17:3],
                      VEC[v][2], VEC[v][1:0], $sformatf("vec%0d", v));
        end
        // R1 plain data between frames
        pass_col(32'h1234_5678, 4'b0000, "R1 raw column");
        // R2 start character in lane 1 is not a start
        pass_col(32'h5555_FB07, 4'b0010, "R2 lane1 start");
        // R10 lowest index wins when two entries match
        ent_en = 4'b1111; ent_id[59:45] = 15'h0012; ent_mode[3] = 1'b0;
        run_frame(1'b1, 8'hD5, 1'b0, 15'h0012, 1'b1, 2'd0, "R10 priority");
        // R10 higher index reported when only it matches
        ent_id[59:45] = 15'h0077;
        run_frame(1'b1, 8'hD5, 1'b0, 15'h0077, 1'b1, 2'd3, "R10 entry3");
        // R11 reset in mid-frame returns idle outputs
        @(negedge clk);
        rx_data = 32'h55D5_55FB; rx_ctrl = 4'b0001;
        @(negedge clk);
        rx_data = 32'hAAAA_AAAA; rx_ctrl = 4'b0000;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset data", 64'(out_data), 64'(IDLE));
        check("R11 mid reset sof", 64'(out_sof), 64'(0));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule